// File: doc/BRIEF.md
# Explicit Branch Target Line Buffer

This block holds a handful of instruction lines between the instruction cache and the decoder. Software fills them ahead of time. A prefetch command names a line and a 24-bit fetch address. The block sends a fill request to the cache side, and the line becomes valid when a matching response returns. There is no predictor. A later switch command picks one of the prefetched lines. Its address and contents are copied into the current line, which the decoder reads.

The current line is a pair of physical lines used as a double buffer. While one half is being executed, the other half is refilled at the next sequential line address. A consume command from the decoder swaps the two halves. A direct jump loads the current pair straight from a given address and stalls until the fill returns. A switch stalls only when the line it names has not been filled yet.

There are eight general target lines and four lines reserved for the control stack. The target lines are selected by a 3-bit ID. The stack lines are selected by a group flag and the low two ID bits. The data pipelines have no path to read or write any of these lines.

Top module: `ebtb_line_buffer`

## Requirements
- R1: After reset, `stall` is 1 and `req_valid` is 0.
- R2: A direct jump invalidates the active half of the current pair and loads it with the jump address. `stall` is 1 from the next cycle until that half's fill returns. Then `cur_addr` equals the jump address and `cur_data` equals the response data.
- R3: Whenever the current half is (re)loaded, the other half is loaded with the current address plus 16, which is one line of four 32-bit words. A consume while not stalled swaps the halves, so `cur_addr` advances by 16. The half just left is then reloaded at the new current address plus 16.
- R4: A switch to a valid line makes that line's address and data appear on `cur_addr`/`cur_data` one cycle later with `stall` 0. The source line keeps its contents.
- R5: A switch to a line that is not yet valid raises `stall` and waits. When that line's fill arrives, its contents are copied into the current line and `stall` falls.
- R6: Each line carries a fill tag that advances on every reload. A response whose tag differs from the line's present tag is discarded. So a second prefetch to a line with a fill still outstanding yields only the second address's data.
- R7: At most one fill request is offered per cycle. The order is: active half of the current pair, then the other half, then target lines 0 to 7, then stack lines 0 to 3. A request stays offered while `req_ready` is 0.
- R8: `pf_stack`/`sw_stack` set to 1 address stack line `id[1:0]`. These four lines are distinct from target lines with the same ID.
- R9: A consume is ignored while `stall` is 1.
- R10: A jump cancels a switch that is waiting. A jump in the same cycle as a switch takes precedence.
- R11: `cur_data` holds word w of a line in bits [32w+31:32w], exactly as delivered on `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pf_valid | input | 1 | Prefetch command |
| pf_stack | input | 1 | Prefetch targets the stack group |
| pf_id | input | 3 | Line ID for the prefetch |
| pf_addr | input | 24 | Fetch address for the prefetch |
| sw_valid | input | 1 | Switch command |
| sw_stack | input | 1 | Switch source is in the stack group |
| sw_id | input | 3 | Line ID for the switch |
| jmp_valid | input | 1 | Direct jump command |
| jmp_addr | input | 24 | Jump address |
| consume | input | 1 | Decoder has finished the current half |
| req_valid | output | 1 | Fill request offered |
| req_ready | input | 1 | Cache accepts the request |
| req_line | output | 4 | Physical line index of the request |
| req_tag | output | 2 | Fill tag of the request |
| req_addr | output | 24 | Address to fetch |
| rsp_valid | input | 1 | Fill response present |
| rsp_line | input | 4 | Physical line index of the response |
| rsp_tag | input | 2 | Fill tag echoed by the cache |
| rsp_data | input | 128 | Line data |
| cur_addr | output | 24 | Address of the current line |
| cur_data | output | 128 | Contents of the current line |
| stall | output | 1 | Current line is not usable |

## Verification
All commands act at the next clock edge. A switch to a valid line is visible on the outputs one cycle after it is applied. A request becomes visible the cycle after the command that creates it, and is taken at the edge where `req_ready` is high. The bench's cache model answers three edges after the grant, so a jump's line is current four edges after the jump. The bench drives and samples on the falling edge. Stall-dependent results are read after a bounded wait for `stall` to fall. The request order is checked one grant per falling edge with `req_ready` held high.

// File: rtl/ebtb_line_buffer.sv
module ebtb_line_buffer #(
  parameter int AW    = 24,
  parameter int IW    = 32,
  parameter int WORDS = 4,
  parameter int NTGT  = 8,
  parameter int NSTK  = 4,
  parameter int TW    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pf_valid,
  input  logic                         pf_stack,
  input  logic [$clog2(NTGT)-1:0]      pf_id,
  input  logic [AW-1:0]                pf_addr,
  input  logic                         sw_valid,
  input  logic                         sw_stack,
  input  logic [$clog2(NTGT)-1:0]      sw_id,
  input  logic                         jmp_valid,
  input  logic [AW-1:0]                jmp_addr,
  input  logic                         consume,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [$clog2(2+NTGT+NSTK)-1:0] req_line,
  output logic [TW-1:0]                req_tag,
  output logic [AW-1:0]                req_addr,
  input  logic                         rsp_valid,
  input  logic [$clog2(2+NTGT+NSTK)-1:0] rsp_line,
  input  logic [TW-1:0]                rsp_tag,
  input  logic [WORDS*IW-1:0]          rsp_data,
  output logic [AW-1:0]                cur_addr,
  output logic [WORDS*IW-1:0]          cur_data,
  output logic                         stall
);
  localparam int NL   = 2 + NTGT + NSTK;
  localparam int LW   = $clog2(NL);
  localparam int IDW  = $clog2(NTGT);
  localparam int SIDW = $clog2(NSTK);
  localparam int DW   = WORDS * IW;
  localparam logic [AW-1:0] STEP = AW'(WORDS * IW / 8);

  logic [NL-1:0] lv, lneed, lwait;
  logic [AW-1:0] laddr [NL];
  logic [DW-1:0] ldata [NL];
  logic [TW-1:0] ltag  [NL];
  logic          act, sw_pend;
  logic [LW-1:0] sw_line;

  function automatic logic [LW-1:0] line_of(input logic stk, input logic [IDW-1:0] id);
    if (stk) return LW'(2 + NTGT) + LW'(id[SIDW-1:0]);
    return LW'(2) + LW'(id);
  endfunction

  logic [LW-1:0] la, lb, sw_sel, pick;
  logic          sw_now, do_copy, do_cons, grant, rsp_hit;
  logic [NL-1:0] ld_en;
  logic [AW-1:0] ld_addr [NL];

  assign la      = LW'(act);
  assign lb      = LW'(!act);
  assign sw_now  = sw_valid | sw_pend;
  assign sw_sel  = sw_valid ? line_of(sw_stack, sw_id) : sw_line;
  assign do_copy = !jmp_valid && sw_now && lv[sw_sel];
  assign do_cons = !jmp_valid && !sw_now && consume && lv[la];
  assign rsp_hit = rsp_valid && lwait[rsp_line] && (rsp_tag == ltag[rsp_line]);

  always_comb begin
    ld_en = '0;
    for (int i = 0; i < NL; i++) ld_addr[i] = '0;
    if (pf_valid) begin
      ld_en[line_of(pf_stack, pf_id)]   = 1'b1;
      ld_addr[line_of(pf_stack, pf_id)] = pf_addr;
    end
    if (jmp_valid) begin
      ld_en[la] = 1'b1;  ld_addr[la] = jmp_addr;
      ld_en[lb] = 1'b1;  ld_addr[lb] = jmp_addr + STEP;
    end else if (do_copy) begin
      ld_en[lb] = 1'b1;  ld_addr[lb] = laddr[sw_sel] + STEP;
    end else if (do_cons) begin
      ld_en[la] = 1'b1;  ld_addr[la] = laddr[lb] + STEP;
    end
  end

  always_comb begin
    logic [LW-1:0] li;
    pick      = '0;
    req_valid = 1'b0;
    for (int k = NL - 1; k >= 0; k--) begin
      li = (k == 0) ? la : (k == 1) ? lb : LW'(k);
      if (lneed[li]) begin
        req_valid = 1'b1;
        pick      = li;
      end
    end
  end

  assign grant    = req_valid && req_ready;
  assign req_line = pick;
  assign req_tag  = ltag[pick];
  assign req_addr = laddr[pick];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv      <= '0;
      lneed   <= '0;
      lwait   <= '0;
      act     <= 1'b0;
      sw_pend <= 1'b0;
      sw_line <= '0;
      for (int i = 0; i < NL; i++) begin
        laddr[i] <= '0;
        ldata[i] <= '0;
        ltag[i]  <= '0;
      end
    end else begin
      if (grant) begin
        lneed[pick] <= 1'b0;
        lwait[pick] <= 1'b1;
      end
      if (rsp_hit) begin
        ldata[rsp_line] <= rsp_data;
        lv[rsp_line]    <= 1'b1;
        lwait[rsp_line] <= 1'b0;
      end
      for (int i = 0; i < NL; i++) begin
        if (ld_en[i]) begin
          laddr[i] <= ld_addr[i];
          lv[i]    <= 1'b0;
          lneed[i] <= 1'b1;
          lwait[i] <= 1'b0;
          ltag[i]  <= ltag[i] + TW'(1);
        end
      end
      if (jmp_valid) begin
        sw_pend <= 1'b0;
      end else if (do_copy) begin
        laddr[la] <= laddr[sw_sel];
        ldata[la] <= ldata[sw_sel];
        lv[la]    <= 1'b1;
        lneed[la] <= 1'b0;
        lwait[la] <= 1'b0;
        ltag[la]  <= ltag[la] + TW'(1);
        sw_pend   <= 1'b0;
      end else if (sw_valid) begin
        sw_pend <= 1'b1;
        sw_line <= sw_sel;
      end else if (do_cons) begin
        act <= !act;
      end
    end
  end

  assign cur_addr = laddr[la];
  assign cur_data = ldata[la];
  assign stall    = !lv[la] || sw_pend;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (stall && !req_valid));

  p_jump_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> (stall && cur_addr == $past(jmp_addr)));

  p_consume_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !stall && !jmp_valid && !sw_valid) |=> (cur_addr == $past(cur_addr) + STEP));

  p_switch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && !jmp_valid && lv[sw_sel]) |=> (!stall && cur_addr == $past(laddr[sw_sel])));

  p_switch_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && !jmp_valid && !lv[sw_sel]) |=> stall);

  p_consume_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && stall && !sw_pend && !jmp_valid && !sw_valid) |=> $stable(cur_addr));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !pf_valid && !jmp_valid && !sw_valid && !consume && !sw_pend)
      |=> (req_valid && $stable(req_addr)));
endmodule

// File: tb/test_ebtb_line_buffer.sv
module test_ebtb_line_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pf_valid = 0, pf_stack = 0, sw_valid = 0, sw_stack = 0, jmp_valid = 0, consume = 0;
  logic [2:0] pf_id = 0, sw_id = 0;
  logic [23:0] pf_addr = 0, jmp_addr = 0;
  logic req_valid, req_ready = 1'b1, rsp_valid, stall;
  logic [3:0] req_line, rsp_line;
  logic [1:0] req_tag, rsp_tag;
  logic [23:0] req_addr, cur_addr;
  logic [127:0] rsp_data, cur_data;

  int vectors = 0, errors = 0;

  always #5 clk = !clk;

  ebtb_line_buffer i_ebtb_line_buffer (.*);

  function automatic logic [127:0] mem(input logic [23:0] a);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = {8'(w + 1), a};
    return r;
  endfunction

  logic        pv [3];
  logic [3:0]  pl [3];
  logic [1:0]  pt [3];
  logic [23:0] pa [3];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin pv[i] <= 0; pl[i] <= 0; pt[i] <= 0; pa[i] <= 0; end
    end else begin
      pv[0] <= req_valid && req_ready; pl[0] <= req_line; pt[0] <= req_tag; pa[0] <= req_addr;
      for (int i = 1; i < 3; i++) begin pv[i] <= pv[i-1]; pl[i] <= pl[i-1]; pt[i] <= pt[i-1]; pa[i] <= pa[i-1]; end
    end
  end
  assign rsp_valid = pv[2];
  assign rsp_line  = pl[2];
  assign rsp_tag   = pt[2];
  assign rsp_data  = mem(pa[2]);

  task automatic chk(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (stall && n < 100) begin @(negedge clk); n++; end
    chk(req, "stall released", stall, 0);
  endtask

  task automatic pf(input logic stk, input logic [2:0] id, input logic [23:0] a);
    pf_valid = 1; pf_stack = stk; pf_id = id; pf_addr = a;
    @(negedge clk); pf_valid = 0;
  endtask

  task automatic sw(input logic stk, input logic [2:0] id);
    sw_valid = 1; sw_stack = stk; sw_id = id;
    @(negedge clk); sw_valid = 0;
  endtask

  task automatic jmp(input logic [23:0] a);
    jmp_valid = 1; jmp_addr = a;
    @(negedge clk); jmp_valid = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] a, exp_ord [5];
    tick(2);
    chk("R1", "stall after reset", stall, 1);
    chk("R1", "req_valid after reset", req_valid, 0);
    rst_n = 1;
    tick(2);
    chk("R1", "stall idle", stall, 1);
    chk("R1", "no request idle", req_valid, 0);

    jmp(24'h001000);
    chk("R2", "stall after jump", stall, 1);
    chk("R7", "jump requested first", req_addr, 24'h001000);
    wait_ready("R2");
    chk("R2", "jump addr", cur_addr, 24'h001000);
    chk("R11", "jump data", cur_data, mem(24'h001000));

    for (int k = 1; k <= 5; k++) begin
      consume = 1; @(negedge clk); consume = 0;
      wait_ready("R3");
      chk("R3", "sequential addr", cur_addr, 24'h001000 + 24'(16 * k));
      chk("R11", "sequential data", cur_data, mem(24'h001000 + 24'(16 * k)));
    end

    jmp(24'h004000);
    consume = 1; tick(2); consume = 0;
    wait_ready("R9");
    chk("R9", "consume during stall ignored", cur_addr, 24'h004000);

    for (int i = 0; i < 12; i++) pf(i >= 8, 3'(i % 8), 24'h200000 + 24'(i * 'h340));
    tick(30);
    for (int i = 0; i < 12; i++) begin
      a = 24'h200000 + 24'(i * 'h340);
      sw(i >= 8, 3'(i % 8));
      chk(i >= 8 ? "R8" : "R4", "switch no stall", stall, 0);
      chk(i >= 8 ? "R8" : "R4", "switch addr", cur_addr, a);
      chk("R11", "switch data", cur_data, mem(a));
    end
    sw(0, 0);
    chk("R4", "source line retained", cur_addr, 24'h200000);

    pf(0, 6, 24'h0ABC00);
    sw(0, 6);
    chk("R5", "switch miss stalls", stall, 1);
    wait_ready("R5");
    chk("R5", "late copy addr", cur_addr, 24'h0ABC00);
    chk("R5", "late copy data", cur_data, mem(24'h0ABC00));

    pf(0, 3, 24'h111100);
    pf(0, 3, 24'h222200);
    tick(20);
    sw(0, 3);
    chk("R6", "reprefetch addr", cur_addr, 24'h222200);
    chk("R6", "stale data discarded", cur_data, mem(24'h222200));

    tick(10);
    req_ready = 0;
    pf(0, 5, 24'h050500);
    pf(0, 2, 24'h020200);
    pf(1, 1, 24'h090900);
    jmp(24'h777000);
    tick(2);
    chk("R7", "request held", req_addr, 24'h777000);
    exp_ord[0] = 24'h777000; exp_ord[1] = 24'h777010; exp_ord[2] = 24'h020200;
    exp_ord[3] = 24'h050500; exp_ord[4] = 24'h090900;
    req_ready = 1;
    for (int k = 0; k < 5; k++) begin
      chk("R7", "request valid", req_valid, 1);
      chk("R7", "request order", req_addr, exp_ord[k]);
      @(negedge clk);
    end
    wait_ready("R7");

    tick(10);
    req_ready = 0;
    pf(0, 4, 24'h0C0C00);
    sw(0, 4);
    chk("R10", "pending switch stalls", stall, 1);
    jmp(24'h0D0D00);
    req_ready = 1;
    wait_ready("R10");
    chk("R10", "jump wins", cur_addr, 24'h0D0D00);
    tick(10);
    chk("R10", "switch cancelled", cur_addr, 24'h0D0D00);
    chk("R10", "no stall after", stall, 0);

    sw_valid = 1; sw_stack = 0; sw_id = 4; jmp_valid = 1; jmp_addr = 24'h0E0E00;
    @(negedge clk); sw_valid = 0; jmp_valid = 0;
    wait_ready("R10");
    chk("R10", "jump beats same-cycle switch", cur_addr, 24'h0E0E00);

    finish_run();
  end
endmodule